// File: doc/BRIEF.md
# SPI Mode Fault Monitor

This block watches the slave-select pin and the serial clock pin of an SPI port that can run as master or as slave. It decides when a mode fault has happened and drives the recovery actions for the rest of the port. As a master, the block treats any select low as another master taking over the bus. As a slave, the block treats a select that rises in the middle of a transfer as a broken frame.

Both pins pass through a two-flop synchronizer, followed by one more flop used for edge detection. A slave transfer is counted in clock edges. How a transfer starts depends on the clock phase. With phase 0, the falling edge of select starts the transfer. With phase 1, the first clock edge that leaves the idle level while select is low starts it. In both phases the transfer ends on the sixteenth edge, which brings the clock back to its idle level.

When a fault is detected, the block does four things. It latches a sticky flag. It pulses one-cycle requests that clear the SPI enable, set the transmit-empty flag and reset the bit-state counter. It hands the shared pins back to general I/O while the flag is set. It raises an error interrupt when that interrupt is enabled. The master/slave selection is an input of this block and is never changed by it, so software can still read that selection after a fault to learn which mode the fault happened in.

Top module: `spi_fault_monitor`

## Requirements
- R1: After a synchronous reset, all outputs are 0. The synchronizers reset to select high and clock low.
- R2: In master mode (`is_master`=1) with `fault_en`=1, a select pin held low sets `fault_flag` three clock edges after the pin is sampled low (two synchronizer stages, then the flag register). With `fault_en`=0, a low select has no effect.
- R3: `fault_flag` stays set until a cycle in which `flag_clr`=1 and no fault event occurs. In that case the flag reads 0 after the next edge. A fault event in the same cycle as `flag_clr` keeps the flag set.
- R4: Each fault event produces a pulse on `spi_en_clr`, `tx_empty_set` and `bit_cnt_rst`, all three in the same cycle that `fault_flag` first reads 1. The pulses last one cycle per fault-event cycle.
- R5: `err_irq` is 1 exactly when `fault_flag`=1 and `err_irq_en`=1. This holds in both master mode and slave mode.
- R6: `pins_to_gpio` is 1 whenever `fault_flag` is 1, and 0 otherwise.
- R7: In slave mode with `cpha`=0, a falling edge of select starts a transfer. If select rises before the transfer ends, a fault is raised, even when no clock edge arrived.
- R8: A slave transfer ends on its sixteenth clock edge, which returns the clock to the idle level given by `cpol`. A select rise after that point raises no fault.
- R9: In slave mode with `cpha`=1, selecting and then deselecting with no clock activity raises no fault. A clock edge that leaves the idle level while select is low starts a transfer, and a select rise before the sixteenth edge raises a fault.
- R10: The transfer tracking above works with idle level 1 (`cpol`=1) as well as with idle level 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ss_pin | input | 1 | Slave-select pin, asynchronous, active low |
| sck_pin | input | 1 | Serial clock pin, asynchronous |
| cpol | input | 1 | Clock polarity, which is also the idle clock level |
| cpha | input | 1 | Clock phase setting |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| fault_en | input | 1 | Enables master-side fault detection |
| err_irq_en | input | 1 | Enables the error interrupt request |
| flag_clr | input | 1 | Strobe that clears the fault flag |
| fault_flag | output | 1 | Sticky mode fault flag |
| err_irq | output | 1 | Error interrupt request |
| spi_en_clr | output | 1 | Pulse requesting that the SPI enable be cleared |
| tx_empty_set | output | 1 | Pulse requesting that the transmit-empty flag be set |
| bit_cnt_rst | output | 1 | Pulse resetting the bit-state counter |
| pins_to_gpio | output | 1 | 1 = shared pins are controlled by general I/O |

## Verification
The hardest cases to reach from the ports are the boundaries of a slave transfer. A select rise must be placed either just before or just after the sixteenth clock edge, and in phase 1 the transfer must start on a clock edge rather than on the select edge. The stimulus therefore drives whole clock trains edge by edge with both polarities: 16 edges, then a rise of select that must be ignored, and 4 or 6 edges, then a rise that must fault. A cycle-by-cycle model that tracks the synchronizer delay is compared with every output on every clock. A master case holds select low while the clear strobe fires, to show that a fault arriving in the same cycle wins over the clear.

// File: rtl/spi_fault_pkg.sv
// Package: shared constants and the synchronized pin view used by the
// SPI mode fault monitor. Assumes an 8-bit frame unless overridden.
package spi_fault_pkg;
    localparam int FRAME_BITS_DEF = 8;

    // Synchronized pin samples plus the previous sample, used for edge detection.
    typedef struct packed {
        logic ss_now;
        logic ss_prev;
        logic sck_now;
        logic sck_prev;
    } pin_view_t;

    // Number of clock edges in a frame of the given length.
    function automatic int edges_per_frame(input int bits);
        return 2 * bits;
    endfunction
endpackage

// File: rtl/spi_fault_sync.sv
// Module: multi-stage synchronizer with an extra delayed copy for edge detection.
// Assumes the inputs are asynchronous levels; reset values are parameters.
module spi_fault_sync #(
    parameter int         WIDTH  = 2,
    parameter int         STAGES = 2,
    parameter logic [1:0] RST    = 2'b10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] dprev
);
    logic [WIDTH-1:0] stg [STAGES];

    // Purpose: shift the raw pins through the synchronizer chain and keep one older copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST[WIDTH-1:0];
            dprev <= RST[WIDTH-1:0];
        end else begin
            stg[0] <= din;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            dprev <= stg[STAGES-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_fault_xfer.sv
// Module: slave transfer tracker. Counts clock edges of one frame and
// reports a fault when select rises while a transfer is active.
// Assumes synchronized pins; is cleared whenever the port is master.
module spi_fault_xfer
    import spi_fault_pkg::*;
#(
    parameter int FRAME_BITS = FRAME_BITS_DEF
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pin_view_t pins,
    input  logic      cpol,
    input  logic      cpha,
    input  logic      is_master,
    output logic      slave_fault,
    output logic      active
);
    localparam int EDGES = edges_per_frame(FRAME_BITS);
    localparam int CNT_W = $clog2(EDGES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(EDGES - 1);

    logic [CNT_W-1:0] cnt;
    logic ss_fell, ss_rose, sck_edge, to_idle, leave_idle;

    // Purpose: decode edges of the synchronized pins.
    always_comb begin
        ss_fell    = pins.ss_prev & ~pins.ss_now;
        ss_rose    = ~pins.ss_prev & pins.ss_now;
        sck_edge   = pins.sck_prev ^ pins.sck_now;
        to_idle    = sck_edge & (pins.sck_now == cpol);
        leave_idle = sck_edge & (pins.sck_now != cpol);
        slave_fault = ~is_master & active & ss_rose;
    end

    // Purpose: start, count and finish a slave transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || is_master || slave_fault) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (!active) begin
            if (!cpha && ss_fell) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (cpha && leave_idle && !pins.ss_now) begin
                active <= 1'b1;
                cnt    <= CNT_W'(1);
            end
        end else if (sck_edge) begin
            if (to_idle && cnt == LAST) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_idle_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> cnt == '0);
    assert_phase1_needs_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && cpha && !leave_idle) |=> !active);
endmodule

// File: rtl/spi_fault_flag.sv
// Module: sticky fault flag and recovery action pulses.
// Assumes fault_evt is a single-cycle qualified fault indication.
module spi_fault_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_evt,
    input  logic flag_clr,
    input  logic err_irq_en,
    output logic fault_flag,
    output logic err_irq,
    output logic spi_en_clr,
    output logic tx_empty_set,
    output logic bit_cnt_rst,
    output logic pins_to_gpio
);
    logic action;

    // Purpose: hold the flag; a new fault wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         fault_flag <= 1'b0;
        else if (fault_evt) fault_flag <= 1'b1;
        else if (flag_clr)  fault_flag <= 1'b0;
    end

    // Purpose: register the one-cycle recovery pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) action <= 1'b0;
        else        action <= fault_evt;
    end

    assign spi_en_clr   = action;
    assign tx_empty_set = action;
    assign bit_cnt_rst  = action;
    assign err_irq      = fault_flag & err_irq_en;
    assign pins_to_gpio = fault_flag;

    assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault_evt |=> fault_flag);
    assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !fault_evt) |=> !fault_flag);
    assert_action_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fault_evt |=> (spi_en_clr && tx_empty_set && bit_cnt_rst));
endmodule

// File: rtl/spi_fault_monitor.sv
// Module: top of the SPI mode fault monitor. Synchronizes the pins,
// detects master and slave faults and drives the recovery outputs.
// Assumes pins are asynchronous; select is active low.
module spi_fault_monitor
    import spi_fault_pkg::*;
#(
    parameter int FRAME_BITS  = FRAME_BITS_DEF,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_pin,
    input  logic sck_pin,
    input  logic cpol,
    input  logic cpha,
    input  logic is_master,
    input  logic fault_en,
    input  logic err_irq_en,
    input  logic flag_clr,
    output logic fault_flag,
    output logic err_irq,
    output logic spi_en_clr,
    output logic tx_empty_set,
    output logic bit_cnt_rst,
    output logic pins_to_gpio
);
    logic [1:0] sync_now, sync_prev;
    pin_view_t  pins;
    logic       slave_fault, master_fault, fault_evt, xfer_active;

    spi_fault_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST(2'b10)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({ss_pin, sck_pin}),
        .dout(sync_now), .dprev(sync_prev)
    );

    // Purpose: pack the synchronized samples into the pin view.
    always_comb begin
        pins.ss_now   = sync_now[1];
        pins.ss_prev  = sync_prev[1];
        pins.sck_now  = sync_now[0];
        pins.sck_prev = sync_prev[0];
    end

    spi_fault_xfer #(.FRAME_BITS(FRAME_BITS)) u_xfer (
        .clk(clk), .rst_n(rst_n), .pins(pins), .cpol(cpol), .cpha(cpha),
        .is_master(is_master), .slave_fault(slave_fault), .active(xfer_active)
    );

    // Purpose: qualify the master-side fault and merge both sources.
    always_comb begin
        master_fault = is_master & fault_en & ~pins.ss_now;
        fault_evt    = master_fault | slave_fault;
    end

    spi_fault_flag u_flag (
        .clk(clk), .rst_n(rst_n), .fault_evt(fault_evt), .flag_clr(flag_clr),
        .err_irq_en(err_irq_en), .fault_flag(fault_flag), .err_irq(err_irq),
        .spi_en_clr(spi_en_clr), .tx_empty_set(tx_empty_set),
        .bit_cnt_rst(bit_cnt_rst), .pins_to_gpio(pins_to_gpio)
    );

    assert_master_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && fault_en && !pins.ss_now) |=> fault_flag);
    assert_no_slave_idle_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_master && !xfer_active) |=> !spi_en_clr || $past(master_fault));
endmodule

// File: tb/spi_fault_monitor_test.sv
module spi_fault_monitor_test;
    logic clk = 0, rst_n = 0;
    logic ss_pin = 1, sck_pin = 0, cpol = 0, cpha = 0, is_master = 0;
    logic fault_en = 0, err_irq_en = 0, flag_clr = 0;
    logic fault_flag, err_irq, spi_en_clr, tx_empty_set, bit_cnt_rst, pins_to_gpio;

    int checks = 0, fails = 0, cycles = 0;
    string cur_req = "R1";

    spi_fault_monitor uut (.*);

    always #4 clk = ~clk;  // 125 MHz

    // Behavioural reference model
    int m_s1, m_s2, m_d, k_s1, k_s2, k_d;
    int m_active, m_edges, m_flag, m_act;

    always @(posedge clk) begin
        int evt, rose, fell, sedge, idle_lvl;
        if (!rst_n) begin
            m_s1 = 1; m_s2 = 1; m_d = 1; k_s1 = 0; k_s2 = 0; k_d = 0;
            m_active = 0; m_edges = 0; m_flag = 0; m_act = 0;
        end else begin
            rose = (m_d == 0 && m_s2 == 1); fell = (m_d == 1 && m_s2 == 0);
            sedge = (k_d != k_s2); idle_lvl = (k_s2 == int'(cpol));
            evt = 0;
            if (is_master) begin
                if (fault_en && m_s2 == 0) evt = 1;
                m_active = 0; m_edges = 0;
            end else if (m_active && rose) begin
                evt = 1; m_active = 0; m_edges = 0;
            end else if (!m_active) begin
                if (!cpha && fell) begin m_active = 1; m_edges = 0; end
                else if (cpha && sedge && !idle_lvl && m_s2 == 0) begin m_active = 1; m_edges = 1; end
            end else if (sedge) begin
                if (idle_lvl && m_edges + 1 == 16) begin m_active = 0; m_edges = 0; end
                else m_edges++;
            end
            m_act = evt;
            if (evt) m_flag = 1; else if (flag_clr) m_flag = 0;
            m_d = m_s2; m_s2 = m_s1; m_s1 = ss_pin;
            k_d = k_s2; k_s2 = k_s1; k_s1 = sck_pin;
        end
        #2;
        chk(fault_flag, m_flag, "flag");
        chk(err_irq, (m_flag != 0) && err_irq_en, "R5 irq");
        chk(spi_en_clr, m_act, "R4 en_clr");
        chk(tx_empty_set, m_act, "R4 tx_set");
        chk(bit_cnt_rst, m_act, "R4 cnt_rst");
        chk(pins_to_gpio, m_flag, "R6 gpio");
    end

    task automatic chk(input logic act, input int exp, input string what);
        checks++;
        if (act !== (exp != 0)) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic expect_flag(input int exp, input string req);
        checks++;
        if (fault_flag !== (exp != 0)) begin
            fails++;
            $display("FAIL %s flag: actual %0b expected %0d", req, fault_flag, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic clear_flag();
        @(negedge clk) flag_clr = 1;
        @(negedge clk) flag_clr = 0;
        wait_n(2);
    endtask

    task automatic clock_edges(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sck_pin = ~sck_pin;
            wait_n(2);
        end
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        @(negedge clk) begin cpol = pol; cpha = pha; sck_pin = pol; ss_pin = 1; end
        wait_n(5);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        cur_req = "R1"; expect_flag(0, "R1");
        @(negedge clk) rst_n = 1;
        wait_n(4); expect_flag(0, "R1");

        // R7: phase 0, select then deselect with no clock
        cur_req = "R7"; err_irq_en = 1; set_mode(0, 0);
        @(negedge clk) ss_pin = 0; wait_n(5);
        @(negedge clk) ss_pin = 1; wait_n(5);
        expect_flag(1, "R7"); clear_flag(); expect_flag(0, "R3");

        // R8: full frame then deselect -> no fault
        cur_req = "R8";
        @(negedge clk) ss_pin = 0; wait_n(4);
        clock_edges(16); wait_n(3);
        @(negedge clk) ss_pin = 1; wait_n(5);
        expect_flag(0, "R8");

        // R7: partial frame then deselect -> fault
        cur_req = "R7";
        @(negedge clk) ss_pin = 0; wait_n(4);
        clock_edges(6);
        @(negedge clk) ss_pin = 1; wait_n(5);
        expect_flag(1, "R7"); clear_flag();

        // R9: phase 1, select/deselect with no clock -> no fault
        cur_req = "R9"; set_mode(0, 1);
        @(negedge clk) ss_pin = 0; wait_n(6);
        @(negedge clk) ss_pin = 1; wait_n(5);
        expect_flag(0, "R9");
        @(negedge clk) ss_pin = 0; wait_n(4);
        clock_edges(4);
        @(negedge clk) ss_pin = 1; wait_n(5);
        expect_flag(1, "R9"); clear_flag();

        // R10: polarity 1, both phases
        cur_req = "R10"; set_mode(1, 1);
        @(negedge clk) ss_pin = 0; wait_n(4);
        clock_edges(16); wait_n(2);
        @(negedge clk) ss_pin = 1; wait_n(5);
        expect_flag(0, "R10");
        @(negedge clk) ss_pin = 0; wait_n(4);
        clock_edges(15);
        @(negedge clk) ss_pin = 1; wait_n(5);
        expect_flag(1, "R10"); clear_flag();
        set_mode(1, 0);
        @(negedge clk) ss_pin = 0; wait_n(4);
        clock_edges(16); wait_n(2);
        @(negedge clk) ss_pin = 1; wait_n(5);
        expect_flag(0, "R10");

        // R2: master mode, enable off then on
        cur_req = "R2"; err_irq_en = 0;
        @(negedge clk) is_master = 1; wait_n(2);
        @(negedge clk) ss_pin = 0; wait_n(6);
        expect_flag(0, "R2");
        @(negedge clk) fault_en = 1; wait_n(3);
        expect_flag(1, "R2");

        // R3: clear while the fault persists keeps the flag
        cur_req = "R3"; clear_flag(); expect_flag(1, "R3");
        cur_req = "R5"; @(negedge clk) err_irq_en = 1; wait_n(2);
        @(negedge clk) ss_pin = 1; wait_n(4);
        cur_req = "R3"; clear_flag(); expect_flag(0, "R3");
        @(negedge clk) fault_en = 0; is_master = 0; wait_n(4);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule